// File: doc/BRIEF.md
# Packed widening pairwise-add and dot-product unit

This unit works on 128-bit packed integer vectors and produces a vector whose lanes are twice as wide as the input lanes. Each output lane k comes from the neighbouring input lanes 2k and 2k+1. Lane 0 sits in the least significant bits. Pairwise add folds one operand, with 8-bit lanes widening to 16-bit lanes or 16-bit lanes widening to 32-bit lanes, and treats the inputs as signed or unsigned. Dot product multiplies two operands of eight signed 16-bit lanes lane by lane and adds each neighbouring pair of products into one of four 32-bit lanes.

The caller presents an opcode, the operands and a valid strobe in the same cycle. The result is captured in a single register stage. A small two-state controller, with states `ST_EMPTY` and `ST_FULL`, tracks whether that register holds a result issued on the previous cycle. The controller has four transitions:

- `ST_EMPTY` to `ST_FULL` on `in_valid`.
- `ST_FULL` to `ST_FULL` on `in_valid`.
- `ST_FULL` to `ST_EMPTY` when `in_valid` is low.
- `ST_EMPTY` to `ST_EMPTY` when `in_valid` is low.

`out_valid` is high exactly in `ST_FULL`.

Top module: `pw_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: Opcode 0 is the signed 8-to-16 fold. Result lane k (bits 16k+15:16k) is the two's-complement sum of byte lanes 2k and 2k+1 of `src_a` (byte j at bits 8j+7:8j), and each byte is sign-extended to 16 bits before the add.
- R4: Opcode 1 is the unsigned 8-to-16 fold. Each byte is zero-extended before the add, so every result lane lies in 0..510.
- R5: Opcode 2 is the signed 16-to-32 fold. Result lane k (bits 32k+31:32k) is the sum of the sign-extended 16-bit lanes 2k and 2k+1 of `src_a` (16-bit lane j at bits 16j+15:16j).
- R6: Opcode 3 is the unsigned 16-to-32 fold. The inputs are zero-extended, so every result lane lies in 0..131070.
- R7: Opcode 4 is the dot product. Result lane k is a[2k]*b[2k] + a[2k+1]*b[2k+1], with all lanes signed 16-bit and the sum taken modulo 2^32. When all four inputs of a pair are -32768 the lane is 0x80000000, with no saturation.
- R8: Opcodes 0 to 3 ignore `src_b`.
- R9: When `in_valid` is low, `out_data` keeps its value on the next cycle.
- R10: Opcodes 5, 6 and 7 produce an all-zero result while `out_valid` still follows `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| op | input | 3 | Operation select: 0 s8 fold, 1 u8 fold, 2 s16 fold, 3 u16 fold, 4 dot product |
| src_a | input | 128 | First operand, lane 0 in the low bits |
| src_b | input | 128 | Second operand, used only by the dot product |
| out_valid | output | 1 | Result register holds the result of the previous cycle's request |
| out_data | output | 128 | Registered widened result |

## Verification
Every cycle, the assertions check several properties:

- The one-cycle relation between `in_valid` and `out_valid`.
- That the result holds while no request arrives.
- The cleared state right after reset.
- The zero result of undefined opcodes.
- The range bound that zero-extension puts on unsigned folds.

Only the bench's vectors can show exact lane sums, signed extension of negative lanes, lane ordering across the vector, the wrap of the extreme dot-product pair, and that `src_b` leaves the folds untouched.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_FOLD8_S  = 3'd0,
        OP_FOLD8_U  = 3'd1,
        OP_FOLD16_S = 3'd2,
        OP_FOLD16_U = 3'd3,
        OP_DOT16    = 3'd4
    } pw_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pw_state_e;

endpackage

// File: rtl/pw_pair_fold.sv
// Folds neighbouring lanes of one vector into lanes of double width.
module pw_pair_fold #(
    parameter int VEC_W = 128,
    parameter int IN_W  = 8
) (
    input  logic [VEC_W-1:0] vec,
    input  logic             is_signed,
    output logic [VEC_W-1:0] folded
);
    localparam int OUT_W    = 2 * IN_W;
    localparam int OUT_LANE = VEC_W / OUT_W;

    for (genvar k = 0; k < OUT_LANE; k++) begin : g_lane
        logic [IN_W-1:0]  lo, hi;
        logic [OUT_W-1:0] lo_x, hi_x;

        assign lo   = vec[(2*k)*IN_W   +: IN_W];
        assign hi   = vec[(2*k+1)*IN_W +: IN_W];
        assign lo_x = {{IN_W{is_signed & lo[IN_W-1]}}, lo};
        assign hi_x = {{IN_W{is_signed & hi[IN_W-1]}}, hi};
        assign folded[k*OUT_W +: OUT_W] = lo_x + hi_x;
    end
endmodule

// File: rtl/pw_dot_pairs.sv
// Signed lane products summed in neighbouring pairs, modulo the output width.
module pw_dot_pairs #(
    parameter int VEC_W = 128,
    parameter int IN_W  = 16
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] dot
);
    localparam int OUT_W    = 2 * IN_W;
    localparam int OUT_LANE = VEC_W / OUT_W;

    for (genvar k = 0; k < OUT_LANE; k++) begin : g_lane
        logic [IN_W-1:0]  a0, a1, b0, b1;
        logic [OUT_W-1:0] p0, p1;

        assign a0 = a[(2*k)*IN_W   +: IN_W];
        assign a1 = a[(2*k+1)*IN_W +: IN_W];
        assign b0 = b[(2*k)*IN_W   +: IN_W];
        assign b1 = b[(2*k+1)*IN_W +: IN_W];
        // low half of the product of sign-extended values is the signed product
        assign p0 = {{IN_W{a0[IN_W-1]}}, a0} * {{IN_W{b0[IN_W-1]}}, b0};
        assign p1 = {{IN_W{a1[IN_W-1]}}, a1} * {{IN_W{b1[IN_W-1]}}, b1};
        assign dot[k*OUT_W +: OUT_W] = p0 + p1;
    end
endmodule

// File: rtl/pw_unit.sv
module pw_unit
    import pw_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int NARROW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    localparam int WIDE = 2 * NARROW;

    pw_state_e        state_q, state_d;
    logic [VEC_W-1:0] res_q, res_d;
    logic [VEC_W-1:0] fold_n, fold_w, dot_w;
    logic             sgn_n, sgn_w;

    assign sgn_n = (op == OP_FOLD8_S);
    assign sgn_w = (op == OP_FOLD16_S);

    pw_pair_fold #(.VEC_W(VEC_W), .IN_W(NARROW)) u_fold_n (
        .vec(src_a), .is_signed(sgn_n), .folded(fold_n)
    );

    pw_pair_fold #(.VEC_W(VEC_W), .IN_W(WIDE)) u_fold_w (
        .vec(src_a), .is_signed(sgn_w), .folded(fold_w)
    );

    pw_dot_pairs #(.VEC_W(VEC_W), .IN_W(WIDE)) u_dot (
        .a(src_a), .b(src_b), .dot(dot_w)
    );

    always_comb begin
        unique case (op)
            OP_FOLD8_S, OP_FOLD8_U:   res_d = fold_n;
            OP_FOLD16_S, OP_FOLD16_U: res_d = fold_w;
            OP_DOT16:                 res_d = dot_w;
            default:                  res_d = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= res_d;
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        out_data  = res_q;
    end
endmodule

// File: rtl/pw_unit_chk.sv
module pw_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       op,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data
);
    function automatic bit fits_u8_fold(logic [VEC_W-1:0] v);
        for (int k = 0; k < VEC_W/16; k++)
            if (v[16*k+9 +: 7] != '0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit fits_u16_fold(logic [VEC_W-1:0] v);
        for (int k = 0; k < VEC_W/32; k++)
            if (v[32*k+17 +: 15] != '0) return 1'b0;
        return 1'b1;
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_data == '0));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_u8_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1) |=> fits_u8_fold(out_data));

    assert_u16_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3) |=> fits_u16_fold(out_data));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 3'd4) |=> (out_data == '0));
endmodule

bind pw_unit pw_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/pw_unit_test.sv
module pw_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pw_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_data(out_data)
    );

    localparam int N = 13;
    localparam logic [2:0] V_OP [N] = '{
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 3'd0, 3'd1, 3'd0, 3'd2, 3'd4, 3'd5, 3'd7
    };
    localparam logic [127:0] V_A [N] = '{
        {16{8'hFF}}, {16{8'hFF}}, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}},
        {8{16'h0002}}, 128'h7F7F0000_00000000_00000000_00000201,
        128'h8080, 128'h8080, 128'h7FFF0001, 128'h00040003,
        {16{8'hFF}}, {16{8'hA5}}
    };
    localparam logic [127:0] V_B [N] = '{
        '0, '0, '0, '0, {8{16'h8000}}, {8{16'hFFFF}}, '0, '0, '0, '0,
        128'hFFFE0005, {16{8'h11}}, '0
    };
    localparam logic [127:0] V_EXP [N] = '{
        {8{16'hFFFE}}, {8{16'h01FE}}, {4{32'hFFFF0000}}, {4{32'h00010000}},
        {4{32'h80000000}}, {4{32'hFFFFFFFC}},
        128'h00FE0000_00000000_00000000_00000003,
        128'h0100, 128'hFF00, 128'h00008000, 128'h7, '0, '0
    };

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        check("R1", {127'b0, out_valid}, '0);
        check("R1", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {127'b0, out_valid}, '0);

        // table walk: inputs at negedge, result one rising edge later
        for (int i = 0; i < N; i++) begin
            op = V_OP[i]; src_a = V_A[i]; src_b = V_B[i]; in_valid = 1'b1;
            @(negedge clk);
            check(tag_of(V_OP[i]), out_data, V_EXP[i]);
            check("R2", {127'b0, out_valid}, 128'd1);
        end

        // R8: same fold with a noisy second operand
        op = 3'd0; src_a = {16{8'hFF}}; src_b = 128'hDEADBEEF_01234567_89ABCDEF_F0F0F0F0;
        @(negedge clk);
        check("R8", out_data, {8{16'hFFFE}});
        op = 3'd3; src_b = {8{16'h8000}}; src_a = {8{16'h8000}};
        @(negedge clk);
        check("R8", out_data, {4{32'h00010000}});

        // R9 and R2: no request, new operands must not change the result
        held = out_data;
        in_valid = 1'b0; op = 3'd4; src_a = {8{16'h1234}}; src_b = {8{16'h0101}};
        @(negedge clk);
        check("R2", {127'b0, out_valid}, '0);
        check("R9", out_data, held);
        @(negedge clk);
        check("R9", out_data, held);

        // R2: single strobe gives single valid cycle
        in_valid = 1'b1; op = 3'd2; src_a = 128'h7FFF0001;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {127'b0, out_valid}, 128'd1);
        check("R5", out_data, 128'h00008000);
        @(negedge clk);
        check("R2", {127'b0, out_valid}, '0);

        // R1: reset in the middle clears the result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {127'b0, out_valid}, '0);
        report();
    end
endmodule